// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block keeps the fetch address of a small processor core. It holds a 13-bit program counter, a 5-bit holding register that software loads ahead of time with the upper address bits, and an eight-slot stack of return addresses. Each cycle the instruction decoder issues one operation code. The code selects one of these actions: hold the address, step to the next word, overwrite the low address byte, jump, call, enter an interrupt, or return.

Upper address bits come from the holding register in two ways. A low-byte write takes all five latched bits. A jump or call supplies an 11-bit target, and only the two highest latched bits are placed above it. Calls and interrupt entries save the full 13-bit address of the next sequential word, so a return restores the page on its own and never touches the holding register. The stack pointer cannot be seen from outside. The stack has no overflow or underflow detection: pushes past the eighth overwrite the oldest entries, and a return from an empty stack moves the pointer backwards around the ring.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter, the holding register, every stack slot and the stack pointer are cleared. After reset, `fetch_addr` is 0000h.
- R2: A step operation adds one to the counter. 1FFFh steps to 0000h.
- R3: A low-byte write loads the counter with the holding register (5 bits) as bits 12:8 and `wr_byte` as bits 7:0.
- R4: A jump loads bits 10:0 from `target` and bits 12:11 from holding-register bits 4:3. The stack is not changed.
- R5: A call saves the counter plus one on the stack and then loads the counter as a jump does.
- R6: An interrupt entry saves the counter plus one on the stack and loads 0004h.
- R7: A return loads the most recently saved 13-bit address and removes it from the stack. It leaves the holding register unchanged.
- R8: The stack is a ring of 8 slots. After nine saves, eight returns give back saves nine down to two, and the ninth return gives save nine again.
- R9: A return from an empty stack steps the pointer back to the previous slot modulo 8 and loads whatever that slot holds. After reset, every slot holds 0000h.
- R10: `pcl_rd` always equals bits 7:0 of `fetch_addr`.
- R11: When `latch_we` is high, the holding register takes `latch_din` at the clock edge. A low-byte write in that same cycle uses the previous holding-register value.
- R12: `op_code` encoding: 0 hold, 1 step, 2 low-byte write, 3 jump, 4 call, 5 interrupt, 6 return, 7 hold. A hold leaves `fetch_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation for this cycle (encoding in R12) |
| wr_byte | input | 8 | Data for a low-byte write |
| target | input | 11 | Jump or call target |
| latch_we | input | 1 | Load enable for the holding register |
| latch_din | input | 5 | New holding-register value |
| fetch_addr | output | 13 | Current fetch address |
| pcl_rd | output | 8 | Low byte of the counter, for readback |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, an 11-bit target and eight stack slots. With these values, overwriting the stack takes only nine calls. The counter wrap at 1FFFh is reached directly through a low-byte write with the holding register set to all ones. Both ring behaviours are therefore exercised in a few dozen cycles. These are the wrap of the ninth save onto the oldest slot and the backwards wrap of a return from an empty stack.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_LOWWR = 3'd2,
        OP_JUMP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_IRQ   = 3'd5,
        OP_RET   = 3'd6,
        OP_SPARE = 3'd7
    } op_e;

    typedef struct packed {
        logic push;
        logic pop;
    } stk_ctl_t;

    function automatic stk_ctl_t stack_ctl(input op_e op);
        stk_ctl_t c;
        c.push = (op == OP_CALL) || (op == OP_IRQ);
        c.pop  = (op == OP_RET);
        return c;
    endfunction

endpackage

// File: rtl/pcs_upper_latch.sv
module pcs_upper_latch #(
    parameter int LATCH_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [LATCH_W-1:0] din,
    output logic [LATCH_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= din;
    end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;
    logic [W-1:0]     slot [DEPTH];

    // Explicit modulo so non-power-of-two depths also form a ring
    assign ptr_inc = (ptr == LAST) ? '0 : ptr + PTR_W'(1);
    assign ptr_dec = (ptr == '0) ? LAST : ptr - PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (push) ptr <= ptr_inc;
        else if (pop)  ptr <= ptr_dec;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                slot[i] <= '0;
            else if (push && ptr == PTR_W'(i))      slot[i] <= push_data;
        end
    end

    assign top_data = slot[ptr_dec];
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
    import pcs_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int TGT_W   = 11,
    parameter int BYTE_W  = 8,
    parameter int LATCH_W = 5,
    parameter int IRQ_VEC = 4
) (
    input  op_e                op,
    input  logic [PC_W-1:0]    pc,
    input  logic [LATCH_W-1:0] upper,
    input  logic [BYTE_W-1:0]  wr_byte,
    input  logic [TGT_W-1:0]   target,
    input  logic [PC_W-1:0]    popped,
    output logic [PC_W-1:0]    pc_nxt,
    output logic [PC_W-1:0]    link
);
    localparam int PG_W = PC_W - TGT_W;

    logic [PC_W-1:0] branch_addr;
    logic [PC_W-1:0] byte_addr;

    assign link        = pc + PC_W'(1);
    assign branch_addr = {upper[LATCH_W-1 -: PG_W], target};
    assign byte_addr   = {upper, wr_byte};

    always_comb begin
        unique case (op)
            OP_STEP:       pc_nxt = link;
            OP_LOWWR:      pc_nxt = byte_addr;
            OP_JUMP,
            OP_CALL:       pc_nxt = branch_addr;
            OP_IRQ:        pc_nxt = PC_W'(IRQ_VEC);
            OP_RET:        pc_nxt = popped;
            default:       pc_nxt = pc;
        endcase
    end
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
    import pcs_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int TGT_W   = 11,
    parameter int BYTE_W  = 8,
    parameter int LATCH_W = PC_W - BYTE_W,
    parameter int DEPTH   = 8,
    parameter int IRQ_VEC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         op_code,
    input  logic [BYTE_W-1:0]  wr_byte,
    input  logic [TGT_W-1:0]   target,
    input  logic               latch_we,
    input  logic [LATCH_W-1:0] latch_din,
    output logic [PC_W-1:0]    fetch_addr,
    output logic [BYTE_W-1:0]  pcl_rd
);
    op_e             op;
    stk_ctl_t        ctl;
    logic [PC_W-1:0] pc_q, pc_nxt, link, popped;
    logic [LATCH_W-1:0] upper;

    assign op  = op_e'(op_code);
    assign ctl = stack_ctl(op);

    pcs_upper_latch #(.LATCH_W(LATCH_W)) u_latch (
        .clk(clk), .rst(rst), .we(latch_we), .din(latch_din), .q(upper)
    );

    pcs_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst(rst), .push(ctl.push), .pop(ctl.pop),
        .push_data(link), .top_data(popped)
    );

    pcs_next_pc #(
        .PC_W(PC_W), .TGT_W(TGT_W), .BYTE_W(BYTE_W),
        .LATCH_W(LATCH_W), .IRQ_VEC(IRQ_VEC)
    ) u_next (
        .op(op), .pc(pc_q), .upper(upper), .wr_byte(wr_byte),
        .target(target), .popped(popped), .pc_nxt(pc_nxt), .link(link)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign fetch_addr = pc_q;
    assign pcl_rd     = pc_q[BYTE_W-1:0];
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
    parameter int PC_W    = 13,
    parameter int TGT_W   = 11,
    parameter int BYTE_W  = 8,
    parameter int IRQ_VEC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_code,
    input logic [BYTE_W-1:0] wr_byte,
    input logic [TGT_W-1:0]  target,
    input logic [PC_W-1:0]   fetch_addr
);
    a_r1_reset_vector: assert property (@(posedge clk)
        $past(rst) |-> fetch_addr == '0);

    a_r2_step_adds_one: assert property (@(posedge clk) disable iff (rst)
        op_code == 3'd1 |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1)));

    a_r3_low_byte_loaded: assert property (@(posedge clk) disable iff (rst)
        op_code == 3'd2 |=> fetch_addr[BYTE_W-1:0] == $past(wr_byte));

    a_r4_branch_target: assert property (@(posedge clk) disable iff (rst)
        (op_code == 3'd3 || op_code == 3'd4) |=> fetch_addr[TGT_W-1:0] == $past(target));

    a_r6_irq_vector: assert property (@(posedge clk) disable iff (rst)
        op_code == 3'd5 |=> fetch_addr == PC_W'(IRQ_VEC));

    a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (op_code == 3'd0 || op_code == 3'd7) |=> $stable(fetch_addr));
endmodule

bind pc_stack_unit pcs_chk #(
    .PC_W(PC_W), .TGT_W(TGT_W), .BYTE_W(BYTE_W), .IRQ_VEC(IRQ_VEC)
) u_pcs_chk (
    .clk(clk), .rst(rst), .op_code(op_code), .wr_byte(wr_byte),
    .target(target), .fetch_addr(fetch_addr)
);

// File: tb/tb_pc_stack_unit.sv
module tb_pc_stack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  wr_byte = '0;
    logic [10:0] target = '0;
    logic        latch_we = 1'b0;
    logic [4:0]  latch_din = '0;
    logic [12:0] fetch_addr;
    logic [7:0]  pcl_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pc_stack_unit dut (
        .clk(clk), .rst(rst), .op_code(op_code), .wr_byte(wr_byte),
        .target(target), .latch_we(latch_we), .latch_din(latch_din),
        .fetch_addr(fetch_addr), .pcl_rd(pcl_rd)
    );

    task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] op, input logic [7:0] b = '0,
                       input logic [10:0] t = '0, input logic lwe = 1'b0,
                       input logic [4:0] ld = '0);
        @(negedge clk);
        op_code = op; wr_byte = b; target = t; latch_we = lwe; latch_din = ld;
        @(posedge clk);
        #1;
        op_code = 3'd0; latch_we = 1'b0;
    endtask

    task automatic set_latch(input logic [4:0] v);
        cyc(3'd0, 8'h00, 11'h0, 1'b1, v);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset fetch", fetch_addr, 13'h0000);
        chk("R10 reset readback", {5'd0, pcl_rd}, 13'h0000);
    endtask

    task automatic t_step();
        repeat (3) cyc(3'd1);
        chk("R2 step", fetch_addr, 13'h0003);
        chk("R10 readback", {5'd0, pcl_rd}, 13'h0003);
    endtask

    task automatic t_low_write();
        set_latch(5'h15);
        cyc(3'd2, 8'hAB);
        chk("R3 low write", fetch_addr, 13'h15AB);
        cyc(3'd2, 8'h22, 11'h0, 1'b1, 5'h03);
        chk("R11 same-cycle latch uses old", fetch_addr, 13'h1522);
        cyc(3'd2, 8'h33);
        chk("R11 latch updated", fetch_addr, 13'h0333);
        chk("R10 readback", {5'd0, pcl_rd}, 13'h0033);
    endtask

    task automatic t_wrap();
        set_latch(5'h1F);
        cyc(3'd2, 8'hFF);
        chk("R3 top address", fetch_addr, 13'h1FFF);
        cyc(3'd1);
        chk("R2 wrap", fetch_addr, 13'h0000);
    endtask

    task automatic t_jump_hold();
        set_latch(5'h0A);
        cyc(3'd3, 8'h00, 11'h123);
        chk("R4 jump", fetch_addr, 13'h0923);
        cyc(3'd0);
        chk("R12 hold", fetch_addr, 13'h0923);
        cyc(3'd7);
        chk("R12 spare code holds", fetch_addr, 13'h0923);
    endtask

    task automatic t_call_ret();
        set_latch(5'h10);
        cyc(3'd4, 8'h00, 11'h7FF);
        chk("R5 call target", fetch_addr, 13'h17FF);
        set_latch(5'h0C);
        cyc(3'd6);
        chk("R7 return restores page", fetch_addr, 13'h0924);
        cyc(3'd2, 8'h40);
        chk("R7 latch untouched by pop", fetch_addr, 13'h0C40);
    endtask

    task automatic t_irq();
        cyc(3'd5);
        chk("R6 irq vector", fetch_addr, 13'h0004);
        cyc(3'd1);
        cyc(3'd6);
        chk("R6 irq return", fetch_addr, 13'h0C41);
    endtask

    task automatic t_circular();
        set_latch(5'h00);
        cyc(3'd2, 8'h00);
        for (int k = 1; k <= 9; k++) cyc(3'd4, 8'h00, 11'(k * 16));
        for (int k = 9; k >= 2; k--) begin
            cyc(3'd6);
            chk("R8 ring pop", fetch_addr, 13'((k - 1) * 16 + 1));
        end
        cyc(3'd6);
        chk("R8 ninth pop sees overwrite", fetch_addr, 13'h0081);
    endtask

    task automatic t_empty();
        do_reset();
        cyc(3'd1); cyc(3'd1);
        cyc(3'd6);
        chk("R9 empty pop reads reset slot", fetch_addr, 13'h0000);
        cyc(3'd1); cyc(3'd1); cyc(3'd1);
        cyc(3'd4, 8'h00, 11'h050);
        chk("R5 call", fetch_addr, 13'h0050);
        cyc(3'd6);
        chk("R9 slot after backwards wrap", fetch_addr, 13'h0004);
        cyc(3'd6);
        chk("R9 second empty pop", fetch_addr, 13'h0000);
    endtask

    initial begin
        t_reset();
        t_step();
        t_low_write();
        t_wrap();
        t_jump_hold();
        t_call_ret();
        t_irq();
        t_circular();
        t_empty();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule